// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block holds the enables, sticky flags and summary request for three interrupt sources: periodic, alarm and update-ended. The event generators sit outside the block. Each one delivers a single-cycle pulse, and that pulse sets the matching flag whatever the state of its enable. Software reads the status byte to see which events happened. The read also clears every flag it reported. The interrupt output is active low and open drain. It is modelled here as an output enable that pulls the line low whenever at least one flag is set together with its own enable.

The block also has an external active-low reset pin, separate from the system reset. While that pin is low and power is good, it clears the three enables, the three flags and the square-wave enable. It leaves every other control bit as it was, and the bus cannot reach the registers while it is held. When power is not good, the block ignores both the external reset and all bus accesses.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets the periodic, alarm or update flag on the next clock edge, whatever the state of its enable.
- R2: A set flag stays set until a status read or an external reset clears it.
- R3: `stat_rdata` shows the summary request in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4, with bits 3..0 zero. An accepted `stat_rd` pulse clears all three flags on the next edge.
- R4: An event that arrives in the same cycle as an accepted status read leaves its flag set after that edge.
- R5: The summary bit and `irq_oe` equal (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable). Clearing an enable while its flag is set releases `irq_oe`.
- R6: An accepted `ctl_wr` loads `ctl_wdata` into the control byte, and `ctl_rdata` reads the byte back. Bit 6 is the periodic enable, bit 5 the alarm enable, bit 4 the update enable and bit 3 the square-wave enable, which also drives `sqw_en`.
- R7: While `ext_reset_n` is low and `pwr_good` is high, each edge clears control bits 6..3, all flags, the summary bit and `irq_oe`. Control bits 7 and 2..0 keep their values.
- R8: While `ext_reset_n` is low, control writes and status reads have no effect.
- R9: While `pwr_good` is low, control writes, status reads and `ext_reset_n` have no effect. Events still set flags.
- R10: The system reset `rst_n` clears the control byte and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| ext_reset_n | input | 1 | External reset pin, active low |
| pwr_good | input | 1 | High when the supply is within limits |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_rdata | output | 8 | Status byte |
| sqw_en | output | 1 | Square-wave enable |
| irq_oe | output | 1 | Pull interrupt line low when high |

## Verification
The assertions assume that each event input is high for one cycle per event and that a status read lasts a single cycle. They also assume that `pwr_good` and `ext_reset_n` change only between edges, like any other synchronous input. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It samples the outputs half a period after the rising edge that should update them. The open-drain line is resolved in the bench as a pulled-up net, low only while `irq_oe` is high.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_reset_n,
  input  logic          pwr_good,
  input  logic          evt_periodic,
  input  logic          evt_alarm,
  input  logic          evt_update,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_rdata,
  input  logic          stat_rd,
  output logic [DW-1:0] stat_rdata,
  output logic          sqw_en,
  output logic          irq_oe
);
  localparam int unsigned B_PIE = 6;
  localparam int unsigned B_AIE = 5;
  localparam int unsigned B_UIE = 4;
  localparam int unsigned B_SQW = 3;
  localparam logic [DW-1:0] CLR_MASK = DW'((1 << B_PIE) | (1 << B_AIE) | (1 << B_UIE) | (1 << B_SQW));

  logic [DW-1:0] ctl_q;
  logic [2:0]    flag_q;
  logic [2:0]    en;
  logic [2:0]    evt;
  logic          hold_clr, acc, rd_clr, irqf;

  assign hold_clr = !ext_reset_n && pwr_good;
  assign acc      = ext_reset_n && pwr_good;
  assign rd_clr   = acc && stat_rd;
  assign evt      = {evt_periodic, evt_alarm, evt_update};
  assign en       = {ctl_q[B_PIE], ctl_q[B_AIE], ctl_q[B_UIE]};
  assign irqf     = |(flag_q & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= '0;
    end else if (hold_clr) begin
      ctl_q  <= ctl_q & ~CLR_MASK;
      flag_q <= '0;
    end else begin
      if (acc && ctl_wr) ctl_q <= ctl_wdata;
      flag_q <= (flag_q & ~{3{rd_clr}}) | evt;
    end
  end

  assign ctl_rdata  = ctl_q;
  assign stat_rdata = DW'({irqf, flag_q, 4'b0000});
  assign sqw_en     = ctl_q[B_SQW];
  assign irq_oe     = irqf;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && evt_alarm) |=> stat_rdata[5]); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr && !rd_clr && stat_rdata[4]) |=> stat_rdata[4]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt_periodic) |=> !stat_rdata[6]); // R3
  AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt_update) |=> stat_rdata[4]); // R4
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:4] == 3'b000) |-> !irq_oe); // R5
  AST_EXT_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (!irq_oe && !sqw_en && ctl_rdata[6:4] == 3'b000 && stat_rdata[7:4] == 4'h0)); // R7
  AST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(ctl_rdata[7]) && $stable(ctl_rdata[2:0]))); // R8
  AST_PWR_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !ctl_rdata[5] && !ctl_rdata[4] && !ctl_rdata[6]) |=> !irq_oe); // R9
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic clk = 0;
  logic rst_n, ext_reset_n, pwr_good;
  logic evt_periodic, evt_alarm, evt_update;
  logic ctl_wr, stat_rd;
  logic [7:0] ctl_wdata, ctl_rdata, stat_rdata;
  logic sqw_en, irq_oe, irq_line;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_reset_n(ext_reset_n), .pwr_good(pwr_good),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .sqw_en(sqw_en), .irq_oe(irq_oe)
  );

  assign irq_line = irq_oe ? 1'b0 : 1'b1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0; ctl_wr = 0; stat_rd = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; step();
  endtask

  task automatic rd_stat();
    stat_rd = 1; step();
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
    chk("R10 ctl", ctl_rdata, 8'h00);
    chk("R10 stat", stat_rdata, 8'h00);
    chk("R10 line", {7'b0, irq_line}, 8'h01);
  endtask

  task automatic t_flags();
    evt_alarm = 1; step();
    chk("R1 alarm no enable", stat_rdata, 8'h20);
    chk("R5 no enable line", {7'b0, irq_line}, 8'h01);
    evt_periodic = 1; step(); step(); step();
    chk("R2 sticky", stat_rdata, 8'h60);
    rd_stat();
    chk("R3 read clears", stat_rdata, 8'h00);
  endtask

  task automatic t_irq();
    wr_ctl(8'h18);
    chk("R6 ctl readback", ctl_rdata, 8'h18);
    chk("R6 sqw", {7'b0, sqw_en}, 8'h01);
    evt_periodic = 1; step();
    chk("R5 unmatched", stat_rdata, 8'h40);
    chk("R5 unmatched oe", {7'b0, irq_oe}, 8'h00);
    evt_update = 1; step();
    chk("R5 matched", stat_rdata, 8'hD0);
    chk("R5 line low", {7'b0, irq_line}, 8'h00);
    wr_ctl(8'h08);
    chk("R5 enable cleared", {7'b0, irq_oe}, 8'h00);
    rd_stat();
  endtask

  task automatic t_race();
    wr_ctl(8'h20);
    evt_alarm = 1; step();
    evt_alarm = 1; stat_rd = 1; step();
    chk("R4 coincident", stat_rdata, 8'hA0);
    rd_stat();
    chk("R4 later read", stat_rdata, 8'h00);
  endtask

  task automatic t_ext_reset();
    wr_ctl(8'hFF);
    evt_update = 1; step();
    chk("R7 pre", stat_rdata, 8'h90);
    ext_reset_n = 0; step();
    chk("R7 ctl", ctl_rdata, 8'h87);
    chk("R7 stat", stat_rdata, 8'h00);
    chk("R7 sqw", {7'b0, sqw_en}, 8'h00);
    wr_ctl(8'h70);
    chk("R8 write ignored", ctl_rdata, 8'h87);
    ext_reset_n = 1; step();
    wr_ctl(8'h40);
    evt_periodic = 1; step();
    ext_reset_n = 0; stat_rd = 1; step();
    ext_reset_n = 1; step();
    chk("R8 ctl after", ctl_rdata, 8'h00);
  endtask

  task automatic t_power();
    wr_ctl(8'h5A);
    evt_periodic = 1; step();
    pwr_good = 0; ext_reset_n = 0; step();
    chk("R9 ext reset ignored", ctl_rdata, 8'h5A);
    chk("R9 flag kept", stat_rdata, 8'hC0);
    ctl_wr = 1; ctl_wdata = 8'h00; step();
    chk("R9 write ignored", ctl_rdata, 8'h5A);
    rd_stat();
    chk("R9 read ignored", stat_rdata, 8'hC0);
    evt_alarm = 1; step();
    chk("R9 event sets", stat_rdata, 8'hE0);
    ext_reset_n = 1; pwr_good = 1; step();
    rd_stat();
    chk("R3 clear all", stat_rdata, 8'h00);
  endtask

  initial begin
    rst_n = 0; ext_reset_n = 1; pwr_good = 1; ctl_wdata = 0;
    evt_periodic = 0; evt_alarm = 0; evt_update = 0; ctl_wr = 0; stat_rd = 0;
    @(negedge clk);
    t_reset();
    t_flags();
    t_irq();
    t_race();
    t_ext_reset();
    t_power();
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done || checks < 0);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20001) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule